// File: doc/BRIEF.md
# Almost-Flag Offset Register Loader

This block fills the two offset registers that a FIFO's almost-full and almost-empty comparators use. One register, Y, holds the almost-full offset. The other, X, holds the almost-empty offset. The loading method is fixed once, at the last clock edge before reset is released, by three pins: a program-mode pin and two select pins. After release, the first select pin carries serial data and the second carries an active-low serial enable.

There are three ways to load the offsets. The first is a fixed preset. The second takes the first two accepted writes on the write port as the offset values. The third shifts in both offsets one bit per clock. While loading is still in progress, the ready output keeps the FIFO's input-ready flag low, or in the parallel method keeps accepted writes out of storage. The store output marks the writes that should go into FIFO memory. The register width `W` must be at least 7 so that the largest preset fits.

Top module: `flag_offset_loader`

## Requirements
- R1: While `rst_n` is low, `ready_o` and `store_o` are 0 at every clock edge.
- R2: If `prog_mode_i`=1 and both selects are 1 at the last reset edge, X and Y both hold 64, and `ready_o` is 1 from the first edge after release.
- R3: If `prog_mode_i`=1, X and Y both hold 16 when only `sel0_sd_i` is 1, and 8 when only `sel1_sen_i` is 1.
- R4: If `prog_mode_i`=1 and both selects are 0, the write mode is parallel. A write is accepted when `wr_en_i` and `ready_o` are both 1 at an edge. The first accepted write loads Y from `wr_data_i[W-1:0]` and the second loads X. `store_o` is 0 for both of these writes.
- R5: In parallel mode `ready_o` is 1 from the first edge after release. From the third accepted write onward, `store_o` equals `wr_en_i`, and X and Y no longer change.
- R6: If `prog_mode_i`=0, `sel0_sd_i`=0 and `sel1_sen_i`=1, the mode is serial. At each edge where `sel1_sen_i` is 0, one bit is taken from `sel0_sd_i`. An edge where `sel1_sen_i` is 1 takes no bit.
- R7: Serial loading takes 2*W bits in total. The first bit lands in the MSB of Y and the last bit lands in the LSB of X. Partial contents move as one 2W-bit left shift, with Y in the upper half.
- R8: In serial mode `ready_o` stays 0 through the edge that takes the last bit and rises at the following edge. Bits offered after the last one are ignored. `store_o` stays 0 while `ready_o` is 0.
- R9: With `prog_mode_i`=0 and any other select pattern, X and Y are 0 and `ready_o` is 1 from the first edge after release.
- R10: In the fixed methods (preset and zero), changes on the select pins or on the write port after release do not alter X or Y. `ready_o`, once 1, stays 1 until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock |
| rst_n | input | 1 | Synchronous active-low reset; the method is decoded while it is low |
| prog_mode_i | input | 1 | Program-mode pin, used only during reset |
| sel0_sd_i | input | 1 | Select 0 during reset; serial data afterwards |
| sel1_sen_i | input | 1 | Select 1 during reset; active-low serial enable afterwards |
| wr_en_i | input | 1 | Write request |
| wr_data_i | input | DW | Write data; the low W bits feed parallel loading |
| x_off_o | output | W | Almost-empty offset X |
| y_off_o | output | W | Almost-full offset Y |
| ready_o | output | 1 | Input-ready gate |
| store_o | output | 1 | The current write goes to FIFO storage |

## Verification
A wrong method decode is visible at the first edge after release: the offsets show the wrong preset, or `ready_o` takes the wrong level. A miscounted serial or parallel counter shows up in one of two ways. Either `ready_o` or `store_o` switches one edge early or late against the reference model, or a stray bit or write changes X or Y after loading has finished. A reversed shift direction or a swapped register order corrupts X and Y as soon as the loading sequence ends. The reference model is compared on every cycle, so each of these faults is reported in the cycle where it first appears.

// File: rtl/flag_offset_loader.sv
module flag_offset_loader #(
  parameter int W  = 10,
  parameter int DW = 36
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prog_mode_i,
  input  logic          sel0_sd_i,
  input  logic          sel1_sen_i,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  output logic [W-1:0]  x_off_o,
  output logic [W-1:0]  y_off_o,
  output logic          ready_o,
  output logic          store_o
);
  localparam int NBITS = 2 * W;
  localparam int CW    = $clog2(NBITS + 1);

  typedef enum logic [1:0] {M_FIXED, M_PAR, M_SER} mode_t;

  mode_t          mode_q, mode_d;
  logic [W-1:0]   x_q, y_q, preset;
  logic [CW-1:0]  bcnt_q;
  logic [1:0]     pcnt_q;
  logic           ready_q;
  logic           accept, par_done, ser_take;

  always_comb begin
    preset = '0;
    mode_d = M_FIXED;
    if (prog_mode_i) begin
      if (sel0_sd_i && sel1_sen_i) preset = W'(64);
      else if (sel0_sd_i)          preset = W'(16);
      else if (sel1_sen_i)         preset = W'(8);
      else                         mode_d = M_PAR;
    end else if (!sel0_sd_i && sel1_sen_i) begin
      mode_d = M_SER;
    end
  end

  assign accept   = wr_en_i && ready_q;
  assign par_done = (pcnt_q == 2'd2);
  assign ser_take = !sel1_sen_i && (bcnt_q != CW'(NBITS));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= mode_d;
      x_q     <= preset;
      y_q     <= preset;
      ready_q <= 1'b0;
      pcnt_q  <= '0;
      bcnt_q  <= '0;
    end else begin
      case (mode_q)
        M_PAR: begin
          ready_q <= 1'b1;
          if (accept && !par_done) begin
            if (pcnt_q == 2'd0) y_q <= wr_data_i[W-1:0];
            else                x_q <= wr_data_i[W-1:0];
            pcnt_q <= pcnt_q + 2'd1;
          end
        end
        M_SER: begin
          if (bcnt_q == CW'(NBITS)) ready_q <= 1'b1;
          if (ser_take) begin
            y_q    <= {y_q[W-2:0], x_q[W-1]};
            x_q    <= {x_q[W-2:0], sel0_sd_i};
            bcnt_q <= bcnt_q + CW'(1);
          end
        end
        default: ready_q <= 1'b1;
      endcase
    end
  end

  assign x_off_o = x_q;
  assign y_off_o = y_q;
  assign ready_o = ready_q;
  assign store_o = accept && (mode_q != M_PAR || par_done);
endmodule

// File: rtl/flag_offset_loader_chk.sv
module flag_offset_loader_chk #(
  parameter int W = 10
) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_en_i,
  input logic [W-1:0] x_off_o,
  input logic [W-1:0] y_off_o,
  input logic         ready_o,
  input logic         store_o
);
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> (!ready_o && !store_o));

  p_store_needs_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    store_o |-> (ready_o && wr_en_i));

  p_ready_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |=> ready_o);

  p_offsets_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    store_o |=> ($stable(x_off_o) && $stable(y_off_o)));
endmodule

bind flag_offset_loader flag_offset_loader_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i),
  .x_off_o(x_off_o), .y_off_o(y_off_o),
  .ready_o(ready_o), .store_o(store_o)
);

// File: tb/flag_offset_loader_tb_top.sv
`timescale 1ns/1ps
module flag_offset_loader_tb_top;
  localparam int W  = 10;
  localparam int DW = 36;

  logic clk = 0, rst_n = 0;
  logic pm = 0, s0 = 0, s1 = 0, we = 0;
  logic [DW-1:0] wd = '0;
  logic [W-1:0] xo, yo;
  logic rdy, st;
  int total = 0, bad = 0, cyc = 0;
  string tag = "R1";

  always #10 clk = ~clk;

  flag_offset_loader #(.W(W), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .prog_mode_i(pm), .sel0_sd_i(s0), .sel1_sen_i(s1),
    .wr_en_i(we), .wr_data_i(wd), .x_off_o(xo), .y_off_o(yo),
    .ready_o(rdy), .store_o(st));

  // reference model: 0 fixed, 1 parallel, 2 serial
  int m_mode = 0, m_x = 0, m_y = 0, m_ready = 0, m_nacc = 0, m_nbits = 0;
  int mask = (1 << W) - 1;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_x = 0;
      if (pm && s0 && s1) m_x = 64;
      else if (pm && s0) m_x = 16;
      else if (pm && s1) m_x = 8;
      else if (pm) m_mode = 1;
      else if (!s0 && s1) m_mode = 2;
      m_y = m_x; m_ready = 0; m_nacc = 0; m_nbits = 0;
    end else if (m_mode == 1) begin
      if (we && m_ready == 1 && m_nacc < 2) begin
        if (m_nacc == 0) m_y = int'(wd[W-1:0]); else m_x = int'(wd[W-1:0]);
        m_nacc++;
      end
      m_ready = 1;
    end else if (m_mode == 2) begin
      if (m_nbits == 2 * W) m_ready = 1;
      if (!s1 && m_nbits < 2 * W) begin
        int c;
        c = ((m_y << W) | m_x);
        c = ((c << 1) | int'(s0)) & ((1 << (2 * W)) - 1);
        m_y = (c >> W) & mask; m_x = c & mask; m_nbits++;
      end
    end else m_ready = 1;
  end

  always @(negedge clk) begin
    int es;
    cyc++;
    es = (we && m_ready == 1 && (m_mode != 1 || m_nacc >= 2)) ? 1 : 0;
    total++;
    if (int'(xo) != m_x || int'(yo) != m_y || int'(rdy) != m_ready || int'(st) != es) begin
      bad++;
      $display("FAIL %s cycle %0d: x=%0d y=%0d rdy=%0d st=%0d expected x=%0d y=%0d rdy=%0d st=%0d",
               tag, cyc, xo, yo, rdy, st, m_x, m_y, m_ready, es);
    end
    if (cyc > 20000) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(string r, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic do_reset(logic p, logic a, logic b);
    @(negedge clk);
    tag = "R1"; rst_n = 0; pm = p; s0 = a; s1 = b; we = 0;
    repeat (3) @(negedge clk);
    chk("R1 ready in reset", int'(rdy), 0);
    chk("R1 store in reset", int'(st), 0);
    rst_n = 1;
  endtask

  task automatic ser_bit(logic b);
    s1 = 0; s0 = b;
    @(negedge clk);
  endtask

  initial begin
    int sv;
    do_reset(1, 1, 1); tag = "R2";
    @(negedge clk);
    chk("R2 x preset 64", int'(xo), 64);
    chk("R2 y preset 64", int'(yo), 64);
    chk("R2 ready", int'(rdy), 1);

    do_reset(1, 1, 0); tag = "R3";
    @(negedge clk);
    chk("R3 x preset 16", int'(xo), 16);
    tag = "R10"; s0 = 0; s1 = 0; we = 1; wd = 36'h3FF;
    repeat (3) @(negedge clk);
    we = 0;
    chk("R10 y still 16", int'(yo), 16);
    chk("R10 ready held", int'(rdy), 1);

    do_reset(1, 0, 1); tag = "R3";
    @(negedge clk);
    chk("R3 y preset 8", int'(yo), 8);

    do_reset(1, 0, 0); tag = "R4";
    we = 1; wd = 36'hF_0000_0155;
    @(negedge clk);
    chk("R4 not accepted before ready", int'(yo), 0);
    chk("R5 ready in parallel", int'(rdy), 1);
    chk("R4 no store on first write", int'(st), 0);
    @(negedge clk);
    wd = 36'h0_0000_03C7;
    chk("R4 y loaded", int'(yo), 'h155);
    @(negedge clk);
    tag = "R5"; wd = 36'h0_0000_0001;
    chk("R4 x loaded", int'(xo), 'h3C7);
    chk("R5 store on third write", int'(st), 1);
    repeat (2) @(negedge clk);
    we = 0;
    chk("R5 x frozen", int'(xo), 'h3C7);
    chk("R5 y frozen", int'(yo), 'h155);

    do_reset(0, 0, 1); tag = "R6";
    @(negedge clk);
    sv = ('h2C5 << W) | 'h13A;
    for (int i = 2 * W - 1; i >= 0; i--) begin
      ser_bit(logic'((sv >> i) & 1));
      if (i == 7) begin s1 = 1; s0 = 1; repeat (2) @(negedge clk); end
      if (i == 0) chk("R8 ready low after last bit", int'(rdy), 0);
    end
    tag = "R8"; s0 = 1;
    @(negedge clk);
    chk("R8 ready after last bit", int'(rdy), 1);
    chk("R7 y serial", int'(yo), 'h2C5);
    chk("R7 x serial", int'(xo), 'h13A);
    repeat (3) @(negedge clk);
    s1 = 1;
    chk("R8 extra bits ignored", int'(xo), 'h13A);
    we = 1; @(negedge clk); we = 0;

    do_reset(0, 1, 0); tag = "R9";
    @(negedge clk);
    chk("R9 x zero", int'(xo), 0);
    chk("R9 ready", int'(rdy), 1);
    do_reset(0, 1, 1); tag = "R9";
    @(negedge clk);
    chk("R9 y zero", int'(yo), 0);

    repeat (2) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule